// File: doc/BRIEF.md
# Accumulator Machine Hardwired Step Controller

This block is the control unit of a small accumulator machine with four instructions: load, add, store and branch-if-zero. It holds a one-hot step register running from T0 to at most T7. A decoder turns the two opcode bits into four mutually exclusive instruction lines. Every control point going to the datapath is a fixed sum of products of the current step, the instruction lines and the accumulator-zero flag.

Each instruction starts with the same fetch. In T0 the program counter goes to the memory address register. In T1 memory is read and the program counter is incremented. In T2 the memory data register is copied into the instruction register. T3 is left free so the opcode can settle. The opcode is captured at the end of T3. From T4 on, the sequence for that instruction runs, and the last step of each sequence sends the counter back to T0.

The datapath, memory and the instruction register itself are outside this block. The controller only sees the opcode bits and the zero flag, and it only drives the fourteen control points.

Top module: `accum_step_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the step is T0. In that step only `pc_drive` and `mar_load` are high.
- R2: Every instruction uses the same fetch. T0 asserts `pc_drive` and `mar_load`. T1 asserts `mem_rd` and `pc_inc`. T2 asserts `mdr_drive` and `ir_load`. T3 asserts no control point.
- R3: Opcode 00 is load. It asserts `ir_addr_drive` and `mar_load` in T4, `mem_rd` in T5, and `mdr_drive` and `acc_load` in T6, then returns to T0. The whole instruction takes 7 cycles.
- R4: Opcode 01 is add. It asserts `ir_addr_drive` and `mar_load` in T4, `mem_rd` in T5, `acc_drive` and `alu_add` in T6, and `tmp_drive` and `acc_load` in T7, then returns to T0. The whole instruction takes 8 cycles.
- R5: Opcode 10 is store. It asserts `ir_addr_drive` and `mar_load` in T4, `acc_drive` and `mdr_load` in T5, and `mem_wr` in T6, then returns to T0. The whole instruction takes 7 cycles. `mem_wr` is never high for any other opcode.
- R6: Opcode 11 is branch-if-zero. In T4 it asserts `ir_addr_drive` and `pc_load` only when `acc_zero` is high; otherwise T4 asserts nothing. T5 asserts nothing and returns to T0. The whole instruction takes 6 cycles.
- R7: The step register is always one-hot. Each cycle it moves up by exactly one step, except that it goes to T0 after the final step of the current instruction.
- R8: The opcode is taken only at the clock edge that ends T3. Changes to the opcode in any other step have no effect on the control points.
- R9: `acc_zero` is ignored in every step except T4 of a branch-if-zero.
- R10: In any cycle, at most one of the bus sources (`pc_drive`, `ir_addr_drive`, `mdr_drive`, `acc_drive`, `tmp_drive`) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 2 | Opcode bits from the instruction register |
| acc_zero | input | 1 | High when the accumulator is zero |
| acc_load | output | 1 | Accumulator takes the value on the bus |
| acc_drive | output | 1 | Accumulator drives the bus |
| alu_add | output | 1 | ALU performs addition |
| ir_load | output | 1 | Instruction register takes the value on the bus |
| ir_addr_drive | output | 1 | Address field of the instruction register drives the bus |
| mar_load | output | 1 | Memory address register takes the value on the bus |
| mdr_load | output | 1 | Memory data register takes the value on the bus |
| mdr_drive | output | 1 | Memory data register drives the bus |
| pc_load | output | 1 | Program counter takes the value on the bus |
| pc_drive | output | 1 | Program counter drives the bus |
| pc_inc | output | 1 | Program counter increments |
| mem_rd | output | 1 | Memory read into the data register |
| tmp_drive | output | 1 | ALU result register drives the bus |
| mem_wr | output | 1 | Memory write from the data register |

## Verification
Several properties are checked by assertions on every cycle:
- the step register stays one-hot and only moves up or returns to T0;
- the captured opcode holds steady outside T3;
- at most one bus source is active at a time;
- the program counter is loaded only in T4 of a taken branch;
- a memory write happens only for store.

Other behaviour can only be shown by the bench scenarios. The full control-word trace of each instruction is compared step by step against an independently built expected sequence. This covers both outcomes of the branch. It also covers the exact length of each instruction, which shows up as alignment of the next fetch. Finally, opcode and zero-flag changes made outside their sampling window must leave that trace unchanged.

// File: rtl/asc_pkg.sv
package asc_pkg;
  localparam int NSTEP = 8;
  localparam int OPW   = 2;
  localparam int NINS  = 1 << OPW;

  typedef enum logic [OPW-1:0] {
    OP_LOAD  = 2'b00,
    OP_ADD   = 2'b01,
    OP_STORE = 2'b10,
    OP_BRZ   = 2'b11
  } op_e;

  typedef struct packed {
    logic ld;
    logic ad;
    logic st;
    logic bz;
  } ins_lines_t;

  typedef struct packed {
    logic acc_load;
    logic acc_drive;
    logic alu_add;
    logic ir_load;
    logic ir_addr_drive;
    logic mar_load;
    logic mdr_load;
    logic mdr_drive;
    logic pc_load;
    logic pc_drive;
    logic pc_inc;
    logic mem_rd;
    logic tmp_drive;
    logic mem_wr;
  } ctrl_word_t;

  // Decode an opcode into mutually exclusive instruction lines.
  function automatic ins_lines_t decode_op(input logic [OPW-1:0] op);
    ins_lines_t l;
    l.ld = (op == OP_LOAD);
    l.ad = (op == OP_ADD);
    l.st = (op == OP_STORE);
    l.bz = (op == OP_BRZ);
    return l;
  endfunction

  // Next one-hot step: back to T0 when the sequence ends, else move up one.
  function automatic logic [NSTEP-1:0] next_step(input logic [NSTEP-1:0] cur,
                                                 input logic last);
    logic [NSTEP-1:0] n;
    if (last) n = {{(NSTEP-1){1'b0}}, 1'b1};
    else      n = {cur[NSTEP-2:0], 1'b0};
    return n;
  endfunction
endpackage

// File: rtl/asc_step_counter.sv
module asc_step_counter
  import asc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_end,
  output logic [NSTEP-1:0] step
);
  localparam logic [NSTEP-1:0] STEP_T0 = {{(NSTEP-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= STEP_T0;
    else        step <= next_step(step, seq_end);
  end

  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(step)); // R7
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_end |=> step == ($past(step) << 1)); // R7
  AST_STEP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |=> step == STEP_T0); // R7
endmodule

// File: rtl/asc_op_decode.sv
module asc_op_decode
  import asc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic [OPW-1:0] opcode,
  output ins_lines_t     lines
);
  logic [OPW-1:0] op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       op_q <= '0;
    else if (capture) op_q <= opcode;
  end

  assign lines = decode_op(op_q);

  AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(op_q)); // R8
  AST_LINES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(lines)); // R8
endmodule

// File: rtl/asc_ctrl_terms.sv
module asc_ctrl_terms
  import asc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTEP-1:0] step,
  input  ins_lines_t       lines,
  input  logic             acc_zero,
  output ctrl_word_t       cw,
  output logic             seq_end
);
  logic mem_op;
  logic br_taken;
  logic [4:0] bus_src;

  assign mem_op   = lines.ld | lines.ad | lines.st;
  assign br_taken = lines.bz & acc_zero & step[4];

  always_comb begin
    cw               = '0;
    cw.pc_drive      = step[0];
    cw.mar_load      = step[0] | (mem_op & step[4]);
    cw.pc_inc        = step[1];
    cw.mem_rd        = step[1] | (lines.ld & step[5]) | (lines.ad & step[5]);
    cw.ir_load       = step[2];
    cw.mdr_drive     = step[2] | (lines.ld & step[6]);
    cw.ir_addr_drive = (mem_op & step[4]) | br_taken;
    cw.pc_load       = br_taken;
    cw.acc_drive     = (lines.st & step[5]) | (lines.ad & step[6]);
    cw.mdr_load      = lines.st & step[5];
    cw.alu_add       = lines.ad & step[6];
    cw.acc_load      = (lines.ld & step[6]) | (lines.ad & step[7]);
    cw.tmp_drive     = lines.ad & step[7];
    cw.mem_wr        = lines.st & step[6];
  end

  assign seq_end = (lines.ld & step[6]) | (lines.ad & step[7]) |
                   (lines.st & step[6]) | (lines.bz & step[5]);

  assign bus_src = {cw.pc_drive, cw.ir_addr_drive, cw.mdr_drive,
                    cw.acc_drive, cw.tmp_drive};

  AST_BUS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_src)); // R10
  AST_PC_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cw.pc_load |-> (acc_zero && step[4] && lines.bz)); // R6
  AST_WRITE_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cw.mem_wr |-> lines.st); // R5
endmodule

// File: rtl/accum_step_ctrl.sv
module accum_step_ctrl
  import asc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] opcode,
  input  logic       acc_zero,
  output logic       acc_load,
  output logic       acc_drive,
  output logic       alu_add,
  output logic       ir_load,
  output logic       ir_addr_drive,
  output logic       mar_load,
  output logic       mdr_load,
  output logic       mdr_drive,
  output logic       pc_load,
  output logic       pc_drive,
  output logic       pc_inc,
  output logic       mem_rd,
  output logic       tmp_drive,
  output logic       mem_wr
);
  localparam int DECODE_STEP = 3;

  logic [NSTEP-1:0] step;
  logic             seq_end;
  logic             op_capture;
  ins_lines_t       lines;
  ctrl_word_t       cw;

  assign op_capture = step[DECODE_STEP];

  asc_step_counter u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .seq_end (seq_end),
    .step    (step)
  );

  asc_op_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (op_capture),
    .opcode  (opcode),
    .lines   (lines)
  );

  asc_ctrl_terms u_terms (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .lines    (lines),
    .acc_zero (acc_zero),
    .cw       (cw),
    .seq_end  (seq_end)
  );

  assign acc_load      = cw.acc_load;
  assign acc_drive     = cw.acc_drive;
  assign alu_add       = cw.alu_add;
  assign ir_load       = cw.ir_load;
  assign ir_addr_drive = cw.ir_addr_drive;
  assign mar_load      = cw.mar_load;
  assign mdr_load      = cw.mdr_load;
  assign mdr_drive     = cw.mdr_drive;
  assign pc_load       = cw.pc_load;
  assign pc_drive      = cw.pc_drive;
  assign pc_inc        = cw.pc_inc;
  assign mem_rd        = cw.mem_rd;
  assign tmp_drive     = cw.tmp_drive;
  assign mem_wr        = cw.mem_wr;

  AST_FETCH_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (step[0] | step[1] | step[2] | step[3]) |-> !(acc_load | pc_load | mem_wr | mdr_load)); // R2
endmodule

// File: tb/accum_step_ctrl_tb_top.sv
module accum_step_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  // Bench bit positions in its own packing of the outputs.
  localparam int B_ACCLD = 0,  B_ACCDR = 1,  B_ALU   = 2,  B_IRLD  = 3;
  localparam int B_IRADR = 4,  B_MARLD = 5,  B_MDRLD = 6,  B_MDRDR = 7;
  localparam int B_PCLD  = 8,  B_PCDR  = 9,  B_PCINC = 10, B_RD    = 11;
  localparam int B_TMPDR = 12, B_WR    = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] opcode = 2'b00;
  logic acc_zero = 1'b0;
  logic acc_load, acc_drive, alu_add, ir_load, ir_addr_drive, mar_load;
  logic mdr_load, mdr_drive, pc_load, pc_drive, pc_inc, mem_rd, tmp_drive, mem_wr;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [13:0] word;
    string       tag;
    int          idx;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  accum_step_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .acc_zero(acc_zero),
    .acc_load(acc_load), .acc_drive(acc_drive), .alu_add(alu_add),
    .ir_load(ir_load), .ir_addr_drive(ir_addr_drive), .mar_load(mar_load),
    .mdr_load(mdr_load), .mdr_drive(mdr_drive), .pc_load(pc_load),
    .pc_drive(pc_drive), .pc_inc(pc_inc), .mem_rd(mem_rd),
    .tmp_drive(tmp_drive), .mem_wr(mem_wr)
  );

  function automatic logic [13:0] observed();
    logic [13:0] w;
    w = '0;
    w[B_ACCLD] = acc_load;  w[B_ACCDR] = acc_drive; w[B_ALU]   = alu_add;
    w[B_IRLD]  = ir_load;   w[B_IRADR] = ir_addr_drive; w[B_MARLD] = mar_load;
    w[B_MDRLD] = mdr_load;  w[B_MDRDR] = mdr_drive; w[B_PCLD]  = pc_load;
    w[B_PCDR]  = pc_drive;  w[B_PCINC] = pc_inc;    w[B_RD]    = mem_rd;
    w[B_TMPDR] = tmp_drive; w[B_WR]    = mem_wr;
    return w;
  endfunction

  // Sequence length per instruction: load/store 7, add 8, branch 6.
  function automatic int seq_len(input logic [1:0] op);
    case (op)
      2'b00: return 7;
      2'b01: return 8;
      2'b10: return 7;
      default: return 6;
    endcase
  endfunction

  // Expected control word in step k, written as a per-step table.
  function automatic logic [13:0] expect_word(input logic [1:0] op, input logic z, input int k);
    logic [13:0] w;
    w = '0;
    case (k)
      0: begin w[B_PCDR] = 1; w[B_MARLD] = 1; end
      1: begin w[B_RD] = 1; w[B_PCINC] = 1; end
      2: begin w[B_MDRDR] = 1; w[B_IRLD] = 1; end
      3: ;
      4: begin
        if (op != 2'b11) begin w[B_IRADR] = 1; w[B_MARLD] = 1; end
        else if (z) begin w[B_IRADR] = 1; w[B_PCLD] = 1; end
      end
      5: begin
        if (op == 2'b00 || op == 2'b01) w[B_RD] = 1;
        else if (op == 2'b10) begin w[B_ACCDR] = 1; w[B_MDRLD] = 1; end
      end
      6: begin
        if (op == 2'b00) begin w[B_MDRDR] = 1; w[B_ACCLD] = 1; end
        else if (op == 2'b01) begin w[B_ACCDR] = 1; w[B_ALU] = 1; end
        else if (op == 2'b10) w[B_WR] = 1;
      end
      7: begin w[B_TMPDR] = 1; w[B_ACCLD] = 1; end
      default: ;
    endcase
    return w;
  endfunction

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Driver: push the expected trace, then drive one instruction.
  // Called just after a falling edge at the start of T0.
  // glitch: drive wrong opcode outside T3 and toggle acc_zero outside its window (R8, R9).
  task automatic run_instr(input logic [1:0] op, input logic z, input bit glitch);
    int len;
    len = seq_len(op);
    for (int k = 0; k < len; k++) begin
      exp_t e;
      e.word = expect_word(op, z, k);
      e.tag  = (k < 4) ? "R2" : op_tag(op);
      if (glitch) e.tag = {e.tag, "/R8/R9"};
      e.tag  = {e.tag, "/R7"};
      e.idx  = k;
      exp_q.push_back(e);
    end
    opcode   = glitch ? ~op : op;
    acc_zero = glitch ? ~z : z;
    for (int k = 1; k < len; k++) begin
      @(negedge clk);
      if (k == 3) begin opcode = op; acc_zero = z; end
      if (glitch && k == 4) opcode = ~op;
      if (glitch && k == 4 && op != 2'b11) acc_zero = ~z;
      if (glitch && k == 5) acc_zero = ~z;
    end
    @(negedge clk);
  endtask

  // Monitor: pop and compare mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && exp_q.size() > 0) begin
        exp_t e;
        logic [13:0] got;
        e = exp_q.pop_front();
        got = observed();
        n_checks++;
        if (got !== e.word) begin
          n_fail++;
          $display("FAIL %s step T%0d: actual %b expected %b", e.tag, e.idx, got, e.word);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    opcode = 2'b11;
    acc_zero = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    n_checks++;
    if (observed() !== expect_word(2'b00, 1'b0, 0)) begin
      n_fail++;
      $display("FAIL R1 reset word: actual %b expected %b", observed(), expect_word(2'b00, 1'b0, 0));
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R1 first cycle after reset is T0, covered by the first popped item
    run_instr(2'b00, 1'b0, 1'b0);  // R3 load
    run_instr(2'b01, 1'b0, 1'b0);  // R4 add
    run_instr(2'b10, 1'b1, 1'b0);  // R5 store
    run_instr(2'b11, 1'b1, 1'b0);  // R6 branch taken
    run_instr(2'b11, 1'b0, 1'b0);  // R6 branch not taken
    run_instr(2'b01, 1'b1, 1'b1);  // R8 R9 add with noisy inputs
    run_instr(2'b00, 1'b1, 1'b1);  // R8 R9 load with noisy inputs
    run_instr(2'b10, 1'b0, 1'b1);  // R8 R9 store with noisy inputs
    run_instr(2'b11, 1'b1, 1'b1);  // R8 R9 branch taken, flag toggles after T4
    run_instr(2'b11, 1'b0, 1'b1);  // R8 R9 branch not taken
    run_instr(2'b01, 1'b0, 1'b0);  // R7 back-to-back after branch
    run_instr(2'b10, 1'b0, 1'b0);  // R10 bus sources across store
    repeat (2) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R7 trace drain: actual %0d left expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule